// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides the result of a fused multiply-add `A*B+C` in the cases where that result must be a NaN. Those cases are: at least one operand is a NaN, or one multiplicand is infinite while the other is zero. The block sits beside the multiply-add datapath. It takes the three operands in the same cycle as the datapath does. One cycle later it reports whether the NaN path applies, which value to return and which exception flags to raise. The surrounding unit uses that result in place of the arithmetic result whenever the NaN indication is high.

Which operand's NaN is propagated is set at run time by a packed 7-bit priority word. The word holds an ordered triple of operand codes and a bit that gives signalling NaNs precedence over quiet ones. A separate 3-bit policy word covers the infinity-times-zero-plus-NaN case: it selects between returning the input NaN and returning the default NaN, and it can suppress the invalid flag. In default-NaN mode the block makes no selection and returns a caller-supplied default pattern. The operand format is parameterised by exponent and fraction widths, with single precision as the default.

Top module: `fma_nan_sel`

## Requirements
- R1: Inputs are captured on a clock edge where `in_vld` is 1. On that edge `out_vld` rises and the new outputs appear. `out_vld` is high for exactly one cycle per strobe and is 0 after reset.
- R2: An operand is a NaN when its exponent field is all ones and its fraction is non-zero. It is signalling when the fraction MSB is 0. With no NaN operand and no infinity-times-zero product, `out_is_nan`, `out_res`, `out_flags` and `out_rule_err` are all 0.
- R3: The priority word names operands by the codes A=0, B=1 and C=2. Bits [1:0] hold the first choice, bits [3:2] the second and bits [5:4] the third. The result is the first NaN operand met in that order.
- R4: When priority bit 6 is 1 and at least one operand is a signalling NaN, only the signalling NaNs are candidates for the ordering of R3.
- R5: A NaN taken from an operand is returned quietened: the fraction MSB is set to 1 and every other bit is kept.
- R6: A priority word is malformed when any of its slots holds code 3 or two slots are equal; a word of zero is therefore malformed. When a NaN must be picked by priority and the word is malformed, `out_rule_err` is 1 and the default pattern is returned.
- R7: With `dnan_mode` at 1, every NaN-path result is `dnan_pat`, whatever the priority and policy words hold, and `out_rule_err` stays 0.
- R8: For an infinity-times-zero product with a NaN addend, policy code [1:0]=1 returns the addend quietened and code 2 returns the default pattern. Code 3 returns the default pattern for a quiet addend and the quietened addend for a signalling one. Code 0 returns the default pattern with `out_rule_err` at 1.
- R9: Any signalling operand sets flag bit 0 (invalid) and bit 13. An infinity-times-zero product sets bit 0 and bit 8, except as stated in R10.
- R10: Policy bit 2, when the addend is a NaN, removes the bit 0 and bit 8 contribution of infinity-times-zero. A signalling addend still sets bits 0 and 13.
- R11: An infinity-times-zero product with a non-NaN addend returns the default pattern, with `out_is_nan` at 1 and flags bit 0 and bit 8 set, regardless of policy bit 2.
- R12: When no strobe occurs, all result outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand strobe |
| op_a | input | W | Multiplicand A |
| op_b | input | W | Multiplicand B |
| op_c | input | W | Addend C |
| pri_rule | input | 7 | Packed priority word: three 2-bit slots and a signalling-first bit |
| izn_rule | input | 3 | Infinity-times-zero policy: code in [1:0], suppress bit in [2] |
| dnan_mode | input | 1 | Default-NaN mode |
| dnan_pat | input | W | Default NaN pattern |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_res | output | W | Selected NaN or default pattern; 0 when not on the NaN path |
| out_is_nan | output | 1 | The NaN path applies to this operation |
| out_flags | output | 16 | Exception flags: bit 0 invalid, bit 8 infinity-times-zero, bit 13 signalling operand |
| out_rule_err | output | 1 | A selection was needed but the governing rule was not usable |

## Verification
Every result is due on the edge that captures the strobe, which is one register stage. The bench drives on a falling edge, raises `in_vld` for one cycle, and reads all outputs at the following falling edge, half a cycle after they were registered. It checks one falling edge later that `out_vld` has dropped. Idle cycles are then inserted and the outputs re-read, which shows that they hold until the next strobe.

// File: rtl/fnan_pkg.sv
package fnan_pkg;

  // Operand class, two bits so that every encoding is meaningful
  typedef enum logic [1:0] {
    K_FIN  = 2'd0,
    K_ZERO = 2'd1,
    K_INF  = 2'd2,
    K_NAN  = 2'd3
  } kind_e;

  localparam int FLAG_W     = 16;
  localparam int FLG_INV    = 0;
  localparam int FLG_IMZ    = 8;
  localparam int FLG_SIG    = 13;
  localparam int RULE_W     = 7;
  localparam int IZN_W      = 3;
  localparam int NUM_OPS    = 3;

  // A priority word is usable when all three slots name distinct operands
  function automatic logic rule_legal(input logic [RULE_W-1:0] rule);
    logic [1:0] s0, s1, s2;
    s0 = rule[1:0];
    s1 = rule[3:2];
    s2 = rule[5:4];
    return (s0 != 2'd3) && (s1 != 2'd3) && (s2 != 2'd3) &&
           (s0 != s1) && (s0 != s2) && (s1 != s2);
  endfunction

  // Walk the slots in order; return {found, operand code}
  function automatic logic [2:0] walk_slots(input logic [RULE_W-1:0] rule,
                                            input logic [NUM_OPS-1:0] cand);
    logic       hit;
    logic [1:0] pick;
    hit  = 1'b0;
    pick = 2'd0;
    for (int s = 0; s < NUM_OPS; s++) begin
      if (!hit && rule[2*s +: 2] != 2'd3 && cand[rule[2*s +: 2]]) begin
        hit  = 1'b1;
        pick = rule[2*s +: 2];
      end
    end
    return {hit, pick};
  endfunction

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
  import fnan_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  output kind_e        kind,
  output logic         sig,
  output logic [W-1:0] quiet
);
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;

  assign ex = val[W-2 -: EXP_W];
  assign fr = val[MAN_W-1:0];

  always_comb begin
    if (&ex)        kind = (fr != '0) ? K_NAN : K_INF;
    else if (ex == '0 && fr == '0) kind = K_ZERO;
    else            kind = K_FIN;
  end

  assign sig   = (kind == K_NAN) && !fr[MAN_W-1];
  assign quiet = val | (W'(1) << (MAN_W-1));
endmodule

// File: rtl/fnan_order_pick.sv
module fnan_order_pick
  import fnan_pkg::*;
(
  input  logic [RULE_W-1:0]  rule,
  input  logic [NUM_OPS-1:0] nan_m,
  input  logic [NUM_OPS-1:0] sig_m,
  output logic [1:0]         sel,
  output logic               ok
);
  logic [NUM_OPS-1:0] cand;
  logic [2:0]         walk;

  // Signalling-first narrows the candidate set before the ordering
  assign cand = (rule[6] && (|sig_m)) ? sig_m : nan_m;
  assign walk = walk_slots(rule, cand);
  assign sel  = walk[1:0];
  assign ok   = rule_legal(rule) && walk[2];
endmodule

// File: rtl/fnan_izn_policy.sv
module fnan_izn_policy (
  input  logic [1:0] code,
  input  logic       addend_sig,
  output logic       take_input,
  output logic       bad
);
  always_comb begin
    take_input = 1'b0;
    bad        = 1'b0;
    unique case (code)
      2'd0: bad        = 1'b1;
      2'd1: take_input = 1'b1;
      2'd2: take_input = 1'b0;
      2'd3: take_input = addend_sig;
    endcase
  end
endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
  import fnan_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [W-1:0]      op_c,
  input  logic [RULE_W-1:0] pri_rule,
  input  logic [IZN_W-1:0]  izn_rule,
  input  logic              dnan_mode,
  input  logic [W-1:0]      dnan_pat,
  output logic              out_vld,
  output logic [W-1:0]      out_res,
  output logic              out_is_nan,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_rule_err
);
  logic [W-1:0]       ops   [NUM_OPS];
  logic [W-1:0]       qv    [NUM_OPS];
  kind_e              kinds [NUM_OPS];
  logic [NUM_OPS-1:0] nan_m, sig_m;

  assign ops[0] = op_a;
  assign ops[1] = op_b;
  assign ops[2] = op_c;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
    fnan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val   (ops[i]),
      .kind  (kinds[i]),
      .sig   (sig_m[i]),
      .quiet (qv[i])
    );
    assign nan_m[i] = (kinds[i] == K_NAN);
  end

  // Named events, also observed by the checker
  logic imz, imz_nan, imz_flag, on_path;
  assign imz      = (kinds[0] == K_INF && kinds[1] == K_ZERO) ||
                    (kinds[0] == K_ZERO && kinds[1] == K_INF);
  assign imz_nan  = imz && nan_m[2];
  assign imz_flag = imz && !(izn_rule[2] && nan_m[2]);
  assign on_path  = (|nan_m) || imz;

  logic [1:0] pick_sel;
  logic       pick_ok;
  fnan_order_pick u_pick (
    .rule  (pri_rule),
    .nan_m (nan_m),
    .sig_m (sig_m),
    .sel   (pick_sel),
    .ok    (pick_ok)
  );

  logic izn_take, izn_bad;
  fnan_izn_policy u_izn (
    .code       (izn_rule[1:0]),
    .addend_sig (sig_m[2]),
    .take_input (izn_take),
    .bad        (izn_bad)
  );

  logic [W-1:0]      d_res;
  logic              d_err, d_from_op;
  logic [FLAG_W-1:0] d_flags;

  always_comb begin
    d_res     = '0;
    d_err     = 1'b0;
    d_from_op = 1'b0;
    if (!on_path) begin
      d_res = '0;
    end else if (dnan_mode) begin
      d_res = dnan_pat;
    end else if (imz_nan) begin
      d_res     = izn_take ? qv[2] : dnan_pat;
      d_from_op = izn_take;
      d_err     = izn_bad;
    end else if (imz) begin
      d_res = dnan_pat;
    end else if (pick_ok) begin
      d_res     = qv[pick_sel];
      d_from_op = 1'b1;
    end else begin
      d_res = dnan_pat;
      d_err = 1'b1;
    end
  end

  always_comb begin
    d_flags          = '0;
    d_flags[FLG_INV] = (|sig_m) || imz_flag;
    d_flags[FLG_IMZ] = imz_flag;
    d_flags[FLG_SIG] = |sig_m;
  end

  logic q_from_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld      <= 1'b0;
      out_res      <= '0;
      out_is_nan   <= 1'b0;
      out_flags    <= '0;
      out_rule_err <= 1'b0;
      q_from_op    <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res      <= d_res;
        out_is_nan   <= on_path;
        out_flags    <= d_flags;
        out_rule_err <= d_err;
        q_from_op    <= d_from_op;
      end
    end
  end
endmodule

// File: rtl/fma_nan_sel_chk.sv
module fma_nan_sel_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_vld,
  input logic         out_vld,
  input logic [W-1:0] out_res,
  input logic         out_is_nan,
  input logic [15:0]  out_flags,
  input logic         out_rule_err,
  input logic         q_from_op
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);  // R1
  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);  // R1
  AST_OFF_PATH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_is_nan) |-> (out_flags == '0 && !out_rule_err && out_res == '0));  // R2
  AST_PASSED_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && q_from_op) |-> ((&out_res[W-2 -: EXP_W]) && out_res[MAN_W-1]));  // R5
  AST_ERR_NOT_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_rule_err) |-> (out_is_nan && !q_from_op));  // R6
  AST_DETAIL_HAS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && (out_flags[8] || out_flags[13])) |-> out_flags[0]);  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_res) && $stable(out_flags)));  // R12
endmodule

bind fma_nan_sel fma_nan_sel_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_vld       (in_vld),
  .out_vld      (out_vld),
  .out_res      (out_res),
  .out_is_nan   (out_is_nan),
  .out_flags    (out_flags),
  .out_rule_err (out_rule_err),
  .q_from_op    (q_from_op)
);

// File: tb/fma_nan_sel_bench.sv
module fma_nan_sel_bench;
  localparam int W  = 32;
  localparam int NV = 22;

  // Operand constants (quiet = fraction MSB set)
  localparam logic [31:0] QA = 32'h7FC0_0001, SA = 32'h7F80_0002;
  localparam logic [31:0] QB = 32'h7FC0_0010, SB = 32'h7F80_0020;
  localparam logic [31:0] QC = 32'hFFC0_0100, SC = 32'hFF80_0200;
  localparam logic [31:0] ONE = 32'h3F80_0000, INF = 32'h7F80_0000, ZR = 32'h0;
  localparam logic [31:0] DN = 32'h7FC0_0000;

  // {a, b, c, rule[6:0], izn[2:0], dmode, exp_res, exp_nan, exp_flags, exp_err}
  localparam logic [156:0] VEC [NV] = '{
    {ONE, ONE, ONE, 7'h24, 3'd1, 1'b0, 32'h0,         1'b0, 16'h0000, 1'b0}, // 0 R2
    {QA,  QB,  QC,  7'h24, 3'd1, 1'b0, QA,            1'b1, 16'h0000, 1'b0}, // 1 R3 abc
    {QA,  QB,  QC,  7'h06, 3'd1, 1'b0, QC,            1'b1, 16'h0000, 1'b0}, // 2 R3 cba
    {QA,  QB,  QC,  7'h09, 3'd1, 1'b0, QB,            1'b1, 16'h0000, 1'b0}, // 3 R3 bca
    {ONE, QB,  QC,  7'h18, 3'd1, 1'b0, QC,            1'b1, 16'h0000, 1'b0}, // 4 R3 acb
    {QA,  SB,  ONE, 7'h24, 3'd1, 1'b0, QA,            1'b1, 16'h2001, 1'b0}, // 5 R4 no pref
    {QA,  SB,  ONE, 7'h64, 3'd1, 1'b0, 32'h7FC0_0020, 1'b1, 16'h2001, 1'b0}, // 6 R4 s_abc
    {SA,  QB,  SC,  7'h52, 3'd1, 1'b0, 32'hFFC0_0200, 1'b1, 16'h2001, 1'b0}, // 7 R4 s_cab
    {ONE, ONE, SC,  7'h21, 3'd1, 1'b0, 32'hFFC0_0200, 1'b1, 16'h2001, 1'b0}, // 8 R5
    {QA,  ONE, ONE, 7'h00, 3'd1, 1'b0, DN,            1'b1, 16'h0000, 1'b1}, // 9 R6 zero
    {QA,  ONE, ONE, 7'h25, 3'd1, 1'b0, DN,            1'b1, 16'h0000, 1'b1}, // 10 R6 dup
    {QA,  ONE, ONE, 7'h00, 3'd1, 1'b1, DN,            1'b1, 16'h0000, 1'b0}, // 11 R7
    {INF, ZR,  QC,  7'h24, 3'd1, 1'b0, QC,            1'b1, 16'h0101, 1'b0}, // 12 R8 code1
    {INF, ZR,  QC,  7'h24, 3'd2, 1'b0, DN,            1'b1, 16'h0101, 1'b0}, // 13 R8 code2
    {INF, ZR,  QC,  7'h24, 3'd3, 1'b0, DN,            1'b1, 16'h0101, 1'b0}, // 14 R8 code3 q
    {ZR,  INF, SC,  7'h24, 3'd3, 1'b0, 32'hFFC0_0200, 1'b1, 16'h2101, 1'b0}, // 15 R9 code3 s
    {INF, ZR,  QC,  7'h24, 3'd5, 1'b0, QC,            1'b1, 16'h0000, 1'b0}, // 16 R10
    {INF, ZR,  SC,  7'h24, 3'd5, 1'b0, 32'hFFC0_0200, 1'b1, 16'h2001, 1'b0}, // 17 R10
    {INF, ZR,  ONE, 7'h24, 3'd5, 1'b0, DN,            1'b1, 16'h0101, 1'b0}, // 18 R11
    {INF, ZR,  QC,  7'h24, 3'd0, 1'b0, DN,            1'b1, 16'h0101, 1'b1}, // 19 R8 code0
    {INF, ONE, QC,  7'h24, 3'd2, 1'b0, QC,            1'b1, 16'h0000, 1'b0}, // 20 R8 no imz
    {INF, ZR,  QC,  7'h24, 3'd1, 1'b1, DN,            1'b1, 16'h0101, 1'b0}  // 21 R7
  };

  logic         clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0, dnan_mode = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0, dnan_pat = DN;
  logic [6:0]   pri_rule = '0;
  logic [2:0]   izn_rule = '0;
  logic         out_vld, out_is_nan, out_rule_err;
  logic [W-1:0] out_res;
  logic [15:0]  out_flags;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fma_nan_sel u_fma_nan_sel (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .pri_rule(pri_rule), .izn_rule(izn_rule), .dnan_mode(dnan_mode), .dnan_pat(dnan_pat),
    .out_vld(out_vld), .out_res(out_res), .out_is_nan(out_is_nan),
    .out_flags(out_flags), .out_rule_err(out_rule_err)
  );

  function automatic string vtag(input int i);
    case (i)
      0: return "R2";
      1, 2, 3, 4: return "R3";
      5, 6, 7: return "R4";
      8: return "R5";
      9, 10: return "R6";
      11, 21: return "R7";
      15: return "R9";
      16, 17: return "R10";
      18: return "R11";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic fire(input logic [31:0] a, b, c, input logic [6:0] r,
                      input logic [2:0] z, input logic dm);
    @(negedge clk);
    op_a = a; op_b = b; op_c = c; pri_rule = r; izn_rule = z; dnan_mode = dm;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Reset state (R1, R2)
    repeat (2) @(negedge clk);
    chk("R1", "reset out_vld", 32'(out_vld), 32'd0);
    chk("R2", "reset out_res", out_res, 32'h0);
    chk("R2", "reset flags", 32'(out_flags), 32'h0);
    chk("R6", "reset err", 32'(out_rule_err), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [156:0] v;
      v = VEC[i];
      fire(v[156:125], v[124:93], v[92:61], v[60:54], v[53:51], v[50]);
      chk("R1", $sformatf("vec%0d out_vld", i), 32'(out_vld), 32'd1);
      chk(vtag(i), $sformatf("vec%0d res", i), out_res, v[49:18]);
      chk(vtag(i), $sformatf("vec%0d is_nan", i), 32'(out_is_nan), 32'(v[17]));
      chk(vtag(i), $sformatf("vec%0d flags", i), 32'(out_flags), 32'(v[16:1]));
      chk(vtag(i), $sformatf("vec%0d rule_err", i), 32'(out_rule_err), 32'(v[0]));
    end

    // R1: strobe is a single-cycle pulse; R12: outputs hold while idle
    @(negedge clk);
    chk("R1", "pulse ends", 32'(out_vld), 32'd0);
    op_a = SA; op_c = ONE; izn_rule = 3'd2;
    repeat (3) @(negedge clk);
    chk("R12", "hold res", out_res, DN);
    chk("R12", "hold flags", 32'(out_flags), 32'h0101);

    // R7: caller pattern returned, malformed rule ignored
    dnan_pat = 32'h7FFF_FFFF;
    fire(SA, QB, QC, 7'h00, 3'd0, 1'b1);
    chk("R7", "custom dnan res", out_res, 32'h7FFF_FFFF);
    chk("R7", "custom dnan err", 32'(out_rule_err), 32'd0);
    chk("R9", "custom dnan flags", 32'(out_flags), 32'h2001);

    // R6: bit 6 alone leaves all slots equal
    dnan_pat = DN;
    fire(ONE, QB, ONE, 7'h40, 3'd1, 1'b0);
    chk("R6", "bit6-only err", 32'(out_rule_err), 32'd1);
    chk("R6", "bit6-only res", out_res, DN);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule